// File: doc/BRIEF.md
# Triple-Copy Voted Register with Scrubbing

This block holds one W-bit word in three independent register copies. A bitwise two-of-three majority of the copies drives the output, so an upset in any one copy never reaches downstream logic. A mode pin selects how a diverged copy is handled. In hold-mode the copies are left as they are and only the output is voted. In scrub-mode every copy reloads the voted word on each cycle without a write, so a corrupted copy is repaired on the next clock edge.

Each copy has its own majority voter, and that voter's result is what the copy reloads. No single voter feeds all three copies. The block also reports which copy disagrees with the voted word, raises a flag when more than one copy disagrees, and keeps a 16-bit saturating count of disagreeing cycles for each copy. A per-copy bit-flip input models an upset in exactly one copy. A fault-injection campaign uses it to exercise masking and repair.

New words enter on a valid/ready port. Ready is always high, so the port never applies back-pressure. A word is accepted on every clock edge where valid is high. All inputs are assumed to be synchronous to the clock already.

Top module: `tmr_vote_reg`

## Requirements
- R1: Each bit of `out_data` is 1 exactly when at least two of the three copies hold 1 in that bit, with every bit voted independently.
- R2: An upset in a single copy, in any number of its bits, leaves `out_data` equal to the last word written.
- R3: With `mode_i` = 0 (hold-mode) and no write, every copy keeps its value. A diverged copy stays diverged and stays flagged until the next accepted write.
- R4: With `mode_i` = 1 (scrub-mode) and no write, every copy loads the voted word at the clock edge. A copy that was diverged is therefore clean after one edge.
- R5: `in_ready` is always 1. A word presented with `in_valid` = 1 is loaded into all three copies at that edge, in either mode.
- R6: `diverge_o[k]` is 1 while copy k differs from `out_data` in at least one bit. Bit 0 belongs to copy 0, bit 1 to copy 1 and bit 2 to copy 2.
- R7: `dis_cnt_o[16k+15:16k]` counts the clock edges at which `diverge_o[k]` was 1. It stops at 65535 and never wraps.
- R8: `multi_fault_o` is 1 exactly when two or more bits of `diverge_o` are 1. Otherwise `diverge_o` is one-hot or zero.
- R9: `upset_i[W*k + b]` = 1 inverts bit b of copy k at that edge. The inversion is applied after the normal write, hold or scrub update.
- R10: While `rst_n` is low, all copies and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 1 | 0 = hold-mode, 1 = scrub-mode |
| in_valid | input | 1 | Write word valid |
| in_ready | output | 1 | Always 1 |
| in_data | input | W | Word to write |
| upset_i | input | 3*W | Per-copy bit inversion, copy k in slice k |
| out_data | output | W | Majority-voted word |
| diverge_o | output | 3 | Copy k disagrees with the voted word |
| multi_fault_o | output | 1 | Two or more copies disagree |
| dis_cnt_o | output | 3*16 | Saturating disagreement counts, copy k in slice k |

## Verification
Three of the block's functions can act in the same cycle: an accepted write, an injected upset, and a scrub. The bench drives a write and an upset to a different copy in the same cycle, and expects that copy to hold the new word with the inverted bits. It also drives a scrub edge together with a fresh upset, and expects the old fault to be repaired while the new one lands. A cycle-accurate model of the three copies in the bench judges each case, comparing the voted word, the flags and the counters on every cycle.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  localparam int unsigned NREP = 3;
  typedef enum logic {
    MODE_HOLD  = 1'b0,
    MODE_SCRUB = 1'b1
  } fix_mode_e;
endpackage

// File: rtl/tmr_maj.sv
module tmr_maj #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_copy.sv
module tmr_copy #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         refresh,
  input  logic [W-1:0] vote_fb,
  input  logic [W-1:0] flip,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    if (load)         nxt = load_data;
    else if (refresh) nxt = vote_fb;
    else              nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt ^ flip;
  end
endmodule

// File: rtl/tmr_sat_cnt.sv
module tmr_sat_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (hit && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_vote_reg.sv
module tmr_vote_reg
  import tmr_vote_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_data,
  input  logic [NREP*W-1:0]    upset_i,
  output logic [W-1:0]         out_data,
  output logic [NREP-1:0]      diverge_o,
  output logic                 multi_fault_o,
  output logic [NREP*CNT_W-1:0] dis_cnt_o
);
  logic [W-1:0] copy_q [NREP];
  logic [W-1:0] fb     [NREP];
  logic         scrub;

  assign in_ready = 1'b1;
  assign scrub    = (fix_mode_e'(mode_i) == MODE_SCRUB);

  for (genvar k = 0; k < NREP; k++) begin : g_rep
    tmr_maj #(.W(W)) u_vote (
      .a(copy_q[0]), .b(copy_q[1]), .c(copy_q[2]), .y(fb[k])
    );
    tmr_copy #(.W(W)) u_copy (
      .clk(clk), .rst_n(rst_n),
      .load(in_valid), .load_data(in_data),
      .refresh(scrub), .vote_fb(fb[k]),
      .flip(upset_i[k*W +: W]),
      .q(copy_q[k])
    );
    assign diverge_o[k] = |(copy_q[k] ^ out_data);
    tmr_sat_cnt #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(diverge_o[k]),
      .cnt(dis_cnt_o[k*CNT_W +: CNT_W])
    );
  end

  assign out_data = fb[0];

  tmr_maj #(.W(1)) u_multi (
    .a(diverge_o[0]), .b(diverge_o[1]), .c(diverge_o[2]), .y(multi_fault_o)
  );
endmodule

// File: rtl/tmr_vote_reg_chk.sv
module tmr_vote_reg_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_i,
  input logic               in_valid,
  input logic               in_ready,
  input logic [W-1:0]       in_data,
  input logic [3*W-1:0]     upset_i,
  input logic [W-1:0]       out_data,
  input logic [2:0]         diverge_o,
  input logic               multi_fault_o,
  input logic [3*CNT_W-1:0] dis_cnt_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  assert_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upset_i == '0) |=> (out_data == $past(in_data) && diverge_o == 3'b000));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !mode_i && upset_i == '0) |=> ($stable(out_data) && $stable(diverge_o)));

  assert_scrub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && mode_i && upset_i == '0) |=> (diverge_o == 3'b000 && $stable(out_data)));

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_fault_o |-> $onehot0(diverge_o));

  for (genvar k = 0; k < 3; k++) begin : g_c
    assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (diverge_o[k] && dis_cnt_o[k*CNT_W +: CNT_W] != TOP) |=>
      dis_cnt_o[k*CNT_W +: CNT_W] == $past(dis_cnt_o[k*CNT_W +: CNT_W]) + 1'b1);
    assert_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cnt_o[k*CNT_W +: CNT_W] == TOP |=> dis_cnt_o[k*CNT_W +: CNT_W] == TOP);
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !diverge_o[k] |=> $stable(dis_cnt_o[k*CNT_W +: CNT_W]));
  end
endmodule

bind tmr_vote_reg tmr_vote_reg_chk #(.W(W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_vote_reg_test.sv
module tmr_vote_reg_test;
  localparam int W = 8;
  localparam int CW = 16;
  localparam int CLK_P = 10;
  localparam int MAXC = 65535;

  logic clk = 0, rst_n = 0, mode_i = 0, in_valid = 0, in_ready;
  logic [W-1:0] in_data = '0, out_data;
  logic [3*W-1:0] upset_i = '0;
  logic [2:0] diverge_o;
  logic multi_fault_o;
  logic [3*CW-1:0] dis_cnt_o;

  tmr_vote_reg #(.W(W), .CNT_W(CW)) uut (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic [2:0]   fl;
    logic         mf;
    int           c [3];
  } exp_t;

  exp_t queue_e [$];
  logic [W-1:0] m [3];
  int mc [3];
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic [W-1:0] maj(logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [2:0] flags_of();
    logic [2:0] f;
    logic [W-1:0] v = maj(m[0], m[1], m[2]);
    for (int k = 0; k < 3; k++) f[k] = (m[k] != v);
    return f;
  endfunction

  task automatic chk(string tag, bit ok, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [W-1:0] d, bit md, logic [3*W-1:0] inj);
    exp_t e;
    logic [2:0] f;
    logic [W-1:0] vt, nx [3];
    @(negedge clk);
    in_valid = v; in_data = d; mode_i = md; upset_i = inj;
    f = flags_of();
    vt = maj(m[0], m[1], m[2]);
    for (int k = 0; k < 3; k++) begin
      if (f[k] && mc[k] < MAXC) mc[k]++;
      nx[k] = v ? d : (md ? vt : m[k]);
      nx[k] ^= inj[k*W +: W];
    end
    for (int k = 0; k < 3; k++) m[k] = nx[k];
    e.q = maj(m[0], m[1], m[2]);
    e.fl = flags_of();
    e.mf = $countones(e.fl) >= 2;
    for (int k = 0; k < 3; k++) e.c[k] = mc[k];
    queue_e.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (queue_e.size() > 0) begin
        e = queue_e.pop_front();
        chk("R1/R2 out_data", out_data == e.q, out_data, e.q);
        chk("R6 diverge_o", diverge_o == e.fl, diverge_o, e.fl);
        chk("R8 multi_fault_o", multi_fault_o == e.mf, multi_fault_o, e.mf);
        for (int k = 0; k < 3; k++)
          chk("R7 dis_cnt_o", int'(dis_cnt_o[k*CW +: CW]) == e.c[k],
              dis_cnt_o[k*CW +: CW], e.c[k]);
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < 3; k++) begin m[k] = '0; mc[k] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_data", out_data == 0, out_data, 0);
    chk("R10 dis_cnt_o", dis_cnt_o == 0, dis_cnt_o, 0);
    chk("R5 in_ready", in_ready == 1, in_ready, 1);
    rst_n = 1;
    // R5 write in hold-mode
    step(1, 8'hA5, 0, '0);
    // R2/R9 whole-word upset in copy 1, then R3 hold keeps it flagged
    step(0, 8'h00, 0, {8'h00, 8'hFF, 8'h00});
    repeat (5) step(0, 8'h00, 0, '0);
    // write and upset to a different copy in the same cycle
    step(1, 8'h3C, 0, {8'h01, 8'h00, 8'h00});
    step(0, 8'h00, 0, '0);
    // R4 scrub repairs copy 2
    step(0, 8'h00, 1, '0);
    step(0, 8'h00, 1, '0);
    // R8 two copies wrong in different bits, under scrub plus new upset
    step(0, 8'h00, 0, {8'h00, 8'h02, 8'h01});
    step(0, 8'h00, 1, {8'h10, 8'h00, 8'h00});
    step(0, 8'h00, 1, '0);
    // R1 two copies flipped in the same bit change the vote
    step(0, 8'h00, 0, {8'h00, 8'h80, 8'h80});
    step(0, 8'h00, 0, '0);
    step(1, 8'h5A, 1, '0);
    // R7 saturation: copy 0 stays diverged in hold-mode
    step(0, 8'h00, 0, {8'h00, 8'h00, 8'h40});
    repeat (65540) step(0, 8'h00, 0, '0);
    // R7 counter holds at top, R5 write clears flag
    step(1, 8'hC3, 0, '0);
    step(0, 8'h00, 0, '0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule